// File: doc/BRIEF.md
# Timed Lock-Bit Read Window

This block sits between a small processor core and the read path of its program memory. Firmware can read the protection (lock) bits with the ordinary program-memory load instruction. To do so it first writes a control register with two bits set together: a configuration-read request and an enable. That single write opens a short window, counted in clock cycles. A load issued inside the window gets the lock-bit byte instead of the program-memory byte. Every other load passes program memory through unchanged.

The window closes by itself in three cases: a load arrives and completes the read, three cycles pass with no load, or four cycles pass with no store. When it closes, both control bits drop to zero. Firmware can see this by reading the control register back. One counter times both limits. It restarts on every arming write.

Top module: `cfg_read_window`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x00 and `ld_data` reads 0x00.
- R2: A control write with bit 1 (request) and bit 0 (enable) both set arms the window. From the next cycle `ctl_rdata` reads 0x03 while the window is open.
- R3: A control write where bits [1:0] are anything other than 2'b11 leaves both bits at 0. If it arrives while the window is open, it closes the window. Loads after it return program memory.
- R4: A load to address 0x0001 in cycle 1, 2 or 3 after the arming write's clock edge returns the lock-bit byte. The low LOCK_BITS bits (default 2) are taken from `lock_src`, and a programmed bit reads 0. All higher bits read 1.
- R5: A load while the window is closed, including a load in cycle 4 after arming, returns `pm_rdata` as sampled with the load.
- R6: A load inside the window completes the read. `ctl_rdata` reads 0x00 from the next cycle.
- R7: With no load, the window stays open through cycle 3 after arming. `ctl_rdata` reads 0x00 from cycle 4 on.
- R8: A store inside the window neither redirects anything nor extends the three-cycle load limit. Without a store, the window also closes by cycle 4.
- R9: A load inside the window to any address other than 0x0001 returns 0xFF and also closes the window.
- R10: `ld_data` is registered. It shows the result one cycle after the load strobe and holds its value in cycles with no load.
- R11: An arming write issued while the window is open restarts the cycle count from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 1 request, bit 0 enable |
| ctl_rdata | output | 8 | Control register read-back |
| ld_strobe | input | 1 | Load instruction issued this cycle |
| ld_addr | input | 16 | Load address |
| st_strobe | input | 1 | Store instruction issued this cycle |
| pm_rdata | input | 8 | Program memory byte at `ld_addr` |
| lock_src | input | 8 | Raw protection bits; 0 means programmed |
| ld_data | output | 8 | Registered load result |

## Verification
Loads to 0x0001 are placed on each cycle from 1 to 4 after arming. This separates the last redirected cycle from the first normal one. Loads to other addresses inside the window, and lock patterns with mixed 0 and 1 bits, show that the unused high bits are forced to 1 and that a stray address returns 0xFF. Four further sequences show whether the window was ever opened or extended: single-bit writes, stores inside the window, re-arming in mid-window, and idle expiry read back through the control register. A behavioural model in the bench is compared with both outputs on every clock.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int EN_BIT  = 0;
  localparam int REQ_BIT = 1;

  typedef struct packed {
    logic req;
    logic en;
  } ctl_bits_t;
endpackage

// File: rtl/cfgwin_ctl.sv
module cfgwin_ctl
  import cfgwin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              close,
  output logic              arm_pulse,
  output logic              armed,
  output logic [DATA_W-1:0] rdata
);
  ctl_bits_t bits_q;

  assign arm_pulse = we && wdata[REQ_BIT] && wdata[EN_BIT];
  assign armed     = bits_q.req && bits_q.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (we) begin
      bits_q.req <= arm_pulse;
      bits_q.en  <= arm_pulse;
    end else if (close) begin
      bits_q <= '0;
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[REQ_BIT] = bits_q.req;
    rdata[EN_BIT]  = bits_q.en;
  end
endmodule

// File: rtl/cfgwin_timer.sv
module cfgwin_timer #(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_pulse,
  input  logic armed,
  input  logic ld,
  input  logic st,
  output logic close
);
  localparam int MAXW = (LD_WIN > ST_WIN) ? LD_WIN : ST_WIN;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt_q;
  logic          st_seen_q;
  logic          ld_expire, st_expire;

  assign ld_expire = (cnt_q == CW'(LD_WIN - 1));
  assign st_expire = !st_seen_q && !st && (cnt_q == CW'(ST_WIN - 1));
  assign close     = armed && (ld || ld_expire || st_expire);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      st_seen_q <= 1'b0;
    end else if (arm_pulse) begin
      cnt_q     <= '0;
      st_seen_q <= 1'b0;
    end else if (armed) begin
      cnt_q     <= cnt_q + 1'b1;
      st_seen_q <= st_seen_q | st;
    end
  end
endmodule

// File: rtl/cfgwin_mux.sv
module cfgwin_mux #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 16,
  parameter int          LOCK_BITS = 2,
  parameter logic [15:0] LOCK_ADDR = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] pm_rdata,
  input  logic [DATA_W-1:0] lock_src,
  output logic [DATA_W-1:0] ld_data
);
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'((1 << LOCK_BITS) - 1);

  logic [DATA_W-1:0] sel;

  always_comb begin
    if (!redirect)
      sel = pm_rdata;
    else if (addr == ADDR_W'(LOCK_ADDR))
      sel = (lock_src & LOCK_MASK) | ~LOCK_MASK;
    else
      sel = '1;
  end

  always_ff @(posedge clk) begin
    if (rst)     ld_data <= '0;
    else if (ld) ld_data <= sel;
  end
endmodule

// File: rtl/cfg_read_window.sv
module cfg_read_window #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 16,
  parameter int          LOCK_BITS = 2,
  parameter logic [15:0] LOCK_ADDR = 16'h0001,
  parameter int          LD_WIN    = 3,
  parameter int          ST_WIN    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              ld_strobe,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_strobe,
  input  logic [DATA_W-1:0] pm_rdata,
  input  logic [DATA_W-1:0] lock_src,
  output logic [DATA_W-1:0] ld_data
);
  logic arm_pulse, armed, close;

  cfgwin_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .close(close),
    .arm_pulse(arm_pulse), .armed(armed), .rdata(ctl_rdata)
  );

  cfgwin_timer #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN)) u_timer (
    .clk(clk), .rst(rst), .arm_pulse(arm_pulse), .armed(armed),
    .ld(ld_strobe), .st(st_strobe), .close(close)
  );

  cfgwin_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_BITS(LOCK_BITS), .LOCK_ADDR(LOCK_ADDR)
  ) u_mux (
    .clk(clk), .rst(rst), .ld(ld_strobe), .redirect(armed), .addr(ld_addr),
    .pm_rdata(pm_rdata), .lock_src(lock_src), .ld_data(ld_data)
  );
endmodule

// File: rtl/cfg_read_window_chk.sv
module cfg_read_window_chk #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] LOCK_ADDR = 16'h0001,
  parameter int          LD_WIN    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [DATA_W-1:0] ctl_wdata,
  input logic [DATA_W-1:0] ctl_rdata,
  input logic              ld_strobe,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [DATA_W-1:0] pm_rdata,
  input logic [DATA_W-1:0] ld_data
);
  logic [3:0] age_q;
  logic       open_w;

  assign open_w = (ctl_rdata[1:0] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst)                                      age_q <= '0;
    else if (ctl_we && ctl_wdata[1:0] == 2'b11)   age_q <= '0;
    else if (open_w && age_q != 4'hF)             age_q <= age_q + 1'b1;
  end

  // R3
  a_r3_partial_write_disarms: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[1:0] != 2'b11) |=> (ctl_rdata[1:0] == 2'b00));

  // R6
  a_r6_load_closes: assert property (@(posedge clk) disable iff (rst)
    (open_w && ld_strobe && !ctl_we) |=> (ctl_rdata[1:0] == 2'b00));

  // R7
  a_r7_window_bounded: assert property (@(posedge clk) disable iff (rst)
    open_w |-> (age_q < 4'(LD_WIN)));

  // R5
  a_r5_closed_passthrough: assert property (@(posedge clk) disable iff (rst)
    (ld_strobe && ctl_rdata[1:0] == 2'b00) |=> (ld_data == $past(pm_rdata)));

  // R9
  a_r9_stray_addr_ff: assert property (@(posedge clk) disable iff (rst)
    (ld_strobe && open_w && ld_addr != ADDR_W'(LOCK_ADDR)) |=> (ld_data == '1));

  // R10
  a_r10_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !ld_strobe |=> $stable(ld_data));
endmodule

bind cfg_read_window cfg_read_window_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .LD_WIN(LD_WIN)
) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .ld_strobe(ld_strobe), .ld_addr(ld_addr),
  .pm_rdata(pm_rdata), .ld_data(ld_data)
);

// File: tb/cfg_read_window_tb.sv
module cfg_read_window_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        ld_strobe = 1'b0;
  logic [15:0] ld_addr = '0;
  logic        st_strobe = 1'b0;
  logic [7:0]  pm_rdata = 8'h5A;
  logic [7:0]  lock_src = 8'hFF;
  logic [7:0]  ld_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cfg_read_window u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ld_strobe(ld_strobe), .ld_addr(ld_addr),
    .st_strobe(st_strobe), .pm_rdata(pm_rdata), .lock_src(lock_src),
    .ld_data(ld_data)
  );

  // Behavioural reference: age = cycles elapsed since arming, -1 when closed.
  int       age = -1;
  bit       stored = 1'b0;
  bit [7:0] exp_ld = 8'h00;
  bit [7:0] exp_ctl = 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      age = -1; stored = 1'b0; exp_ld = 8'h00; exp_ctl = 8'h00;
    end else begin
      if (ld_strobe) begin
        if (age < 0)             exp_ld = pm_rdata;
        else if (ld_addr == 16'd1) exp_ld = {6'h3F, lock_src[1:0]};
        else                     exp_ld = 8'hFF;
      end
      if (ctl_we) begin
        age = (ctl_wdata[1:0] == 2'b11) ? 0 : -1;
        stored = 1'b0;
      end else if (age >= 0) begin
        if (st_strobe) stored = 1'b1;
        if (ld_strobe)                    age = -1;
        else if (age + 1 >= 3)            age = -1;
        else if (!stored && age + 1 >= 4) age = -1;
        else                              age = age + 1;
      end
      exp_ctl = (age >= 0) ? 8'h03 : 8'h00;
    end
  end

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Drive one cycle, then compare both outputs against the model.
  task automatic cyc(string tag, logic we, logic [7:0] wd, logic ld,
                     logic [15:0] a, logic st);
    ctl_we = we; ctl_wdata = wd; ld_strobe = ld; ld_addr = a; st_strobe = st;
    @(posedge clk);
    @(negedge clk);
    check8({tag, " ld_data"}, ld_data, exp_ld);
    check8({tag, " ctl_rdata"}, ctl_rdata, exp_ctl);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 8'h00, 0, 16'h0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check8("R1 reset ld_data", ld_data, 8'h00);
    check8("R1 reset ctl_rdata", ctl_rdata, 8'h00);

    // R5 normal loads while closed
    pm_rdata = 8'h3C;
    cyc("R5 closed load", 0, 0, 1, 16'h0001, 0);
    check8("R5 direct", ld_data, 8'h3C);
    cyc("R10 hold", 0, 0, 0, 16'h0, 0);
    check8("R10 hold direct", ld_data, 8'h3C);

    // R4 load on cycles 1, 2, 3 after arming
    for (int k = 1; k <= 3; k++) begin
      lock_src = (k == 1) ? 8'h02 : (k == 2) ? 8'h01 : 8'h00;
      cyc("R2 arm", 1, 8'h03, 0, 16'h0, 0);
      check8("R2 armed readback", ctl_rdata, 8'h03);
      idle("R4 wait", k - 1);
      cyc("R4 redirected load", 0, 0, 1, 16'h0001, 0);
      check8("R4 lock byte", ld_data, {6'h3F, lock_src[1:0]});
      check8("R6 closed after load", ctl_rdata, 8'h00);
      idle("R6 after", 1);
    end

    // R5 load on cycle 4 -> normal
    pm_rdata = 8'h81;
    cyc("R2 arm", 1, 8'h03, 0, 16'h0, 0);
    idle("R7 wait", 2);
    check8("R7 open at cycle 3", ctl_rdata, 8'h03);
    idle("R7 wait", 1);
    check8("R7 closed at cycle 4", ctl_rdata, 8'h00);
    cyc("R5 cycle4 load", 0, 0, 1, 16'h0001, 0);
    check8("R5 cycle4 direct", ld_data, 8'h81);

    // R7 expiry without any access, then readback
    cyc("R7 arm", 1, 8'h03, 0, 16'h0, 0);
    idle("R7 expiry", 5);
    check8("R7 readback cleared", ctl_rdata, 8'h00);

    // R3 single-bit writes
    cyc("R3 req only", 1, 8'h02, 0, 16'h0, 0);
    check8("R3 req only readback", ctl_rdata, 8'h00);
    pm_rdata = 8'h66;
    cyc("R3 load after req only", 0, 0, 1, 16'h0001, 0);
    check8("R3 normal data", ld_data, 8'h66);
    cyc("R3 en only", 1, 8'h01, 0, 16'h0, 0);
    cyc("R3 load after en only", 0, 0, 1, 16'h0001, 0);
    check8("R3 normal data 2", ld_data, 8'h66);
    cyc("R3 arm", 1, 8'h03, 0, 16'h0, 0);
    cyc("R3 disarm write", 1, 8'h00, 0, 16'h0, 0);
    cyc("R3 load after disarm", 0, 0, 1, 16'h0001, 0);
    check8("R3 disarmed data", ld_data, 8'h66);

    // R9 other address in window
    cyc("R9 arm", 1, 8'h03, 0, 16'h0, 0);
    cyc("R9 stray load", 0, 0, 1, 16'h0002, 0);
    check8("R9 stray 0xFF", ld_data, 8'hFF);
    check8("R9 window ended", ctl_rdata, 8'h00);
    cyc("R9 next load normal", 0, 0, 1, 16'h0001, 0);
    check8("R9 normal after", ld_data, 8'h66);

    // R8 store does not extend the window
    pm_rdata = 8'h17;
    cyc("R8 arm", 1, 8'h03, 0, 16'h0, 0);
    cyc("R8 store", 0, 0, 0, 16'h0, 1);
    idle("R8 wait", 2);
    check8("R8 closed", ctl_rdata, 8'h00);
    cyc("R8 late load", 0, 0, 1, 16'h0001, 0);
    check8("R8 normal data", ld_data, 8'h17);

    // R11 re-arm restarts count
    lock_src = 8'hFE;
    cyc("R11 arm", 1, 8'h03, 0, 16'h0, 0);
    idle("R11 wait", 2);
    cyc("R11 rearm", 1, 8'h03, 0, 16'h0, 0);
    idle("R11 wait", 2);
    check8("R11 still open", ctl_rdata, 8'h03);
    cyc("R11 load", 0, 0, 1, 16'h0001, 0);
    check8("R11 lock byte", ld_data, 8'hFE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule